// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

The block moves outgoing frames from system memory onto a byte stream. Software builds a ring of 16-byte descriptors starting at an aligned base address. Each descriptor holds four 32-bit words: a status word, a tag word, the low half of the buffer address and the high half of the buffer address. The status word carries an ownership flag, an end-of-ring flag, frame start and frame end markers, and the byte length.

Software sets the transmit enable in the command register and then rings the doorbell in the poll register. The engine then reads descriptors one after another from its current index. For each descriptor that hardware owns, it streams the buffer out byte by byte. It then writes the status word back with ownership cleared and pulses a transmit-done strobe. The scan stops at the first descriptor that software still owns.

Only the status word and the low buffer address word are read. The tag word and the high address word are never fetched. All configuration goes through one small write port that selects among the base, command and poll registers.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, no stream byte and no done pulse, and the descriptor index is 0, so the first fetch reads the status word at the ring base.
- R2: A write to the poll register (reg_sel 2) with bit 6 set starts a scan only while transmit enable is set, which is bit 2 of the command register (reg_sel 1). A poll write with bit 6 clear is ignored, and so is any poll write while transmit enable is clear.
- R3: A fetched status word whose bit 31 (ownership) is 0 ends the scan. The engine streams nothing, writes nothing and leaves its index on that descriptor.
- R4: For an owned descriptor, the engine streams exactly the number of bytes given in status bits 12:0. It starts at the byte address held in descriptor word 2, which may have any byte alignment. Bytes come out in little-endian order within each 32-bit memory word.
- R5: The start marker is high on the first byte only when status bit 29 is set. The end marker is high on the last byte only when status bit 28 is set. After the last byte no further byte follows in the next cycle.
- R6: While a byte is offered and tx_ready_i is low, the data byte and both markers hold steady.
- R7: After streaming, the engine writes the status word back to the same address. Bit 31 is cleared and every other bit is kept. tx_ok_o is high for exactly one cycle, in the cycle after the write.
- R8: After each completed descriptor the index advances by one descriptor (16 bytes). After a descriptor whose status bit 30 is set, the next fetch is at the ring base. The scan continues until a descriptor that is not owned is found.
- R9: The ring base register (reg_sel 0) ignores address bits 7:0, which keeps the base 256-byte aligned. Writing the base resets the index to 0.
- R10: A doorbell that arrives during a scan is remembered. When that scan meets a descriptor that is not owned, the engine reads that descriptor's status once more before going idle.
- R11: If transmit enable is cleared during a scan, the current descriptor still completes, with its write-back and done pulse. No further descriptor is then fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 ring base, 1 command, 2 poll |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_sop_o | output | 1 | Frame start marker |
| tx_eop_o | output | 1 | Frame end marker |
| tx_ok_o | output | 1 | One-cycle descriptor done pulse |

## Verification
Frames are sent with random lengths from 60 to 200 bytes and random buffer byte offsets, under random backpressure. This separates correct byte lane order and word stepping from errors that only show up at one alignment or while the sink stalls. Descriptors are built with and without the start and end flags and with the end-of-ring flag, and the read log shows whether the index wraps to the base or runs on. Directed cases cover four more behaviours: a doorbell with enable clear or bit 6 clear, a doorbell during streaming, which must cause a second read of the descriptor that is not owned, enable dropped during a frame, and a base written with stray low bits.

// File: rtl/tde_pkg.sv
package tde_pkg;
  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 30;
  localparam int FS_BIT     = 29;
  localparam int LS_BIT     = 28;
  localparam int LEN_W      = 13;
  localparam int DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int BUF_OFS    = 8;   // byte offset of buffer address low word
  localparam int ALIGN_W    = 8;   // 256-byte ring alignment
  localparam int POLL_BIT   = 6;
  localparam int TXEN_BIT   = 2;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_POLL = 2'd2;

  typedef enum logic [2:0] {
    C_IDLE, C_ST_REQ, C_ST_WAIT, C_BA_REQ, C_BA_WAIT, C_STREAM, C_WB, C_OK
  } ctrl_st_e;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_OUT} strm_st_e;
endpackage

// File: rtl/tde_regs.sv
module tde_regs
  import tde_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] base_o,
  output logic          tx_en_o,
  output logic          doorbell_o,
  output logic          base_wr_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      tx_en_o <= 1'b0;
    end else if (we_i) begin
      if (sel_i == SEL_BASE) base_o <= {wdata_i[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
      if (sel_i == SEL_CMD)  tx_en_o <= wdata_i[TXEN_BIT];
    end
  end

  assign doorbell_o = we_i && (sel_i == SEL_POLL) && wdata_i[POLL_BIT];
  assign base_wr_o  = we_i && (sel_i == SEL_BASE);
endmodule

// File: rtl/tde_streamer.sv
module tde_streamer
  import tde_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          fs_i,
  input  logic          ls_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  output logic          done_o
);
  strm_st_e      st_q;
  logic [AW-1:0] waddr_q;
  logic [1:0]    lane_q;
  logic [LW-1:0] cnt_q;
  logic [31:0]   word_q;
  logic          first_q, fs_q, ls_q;
  logic          last_byte;

  assign last_byte  = (cnt_q == LW'(1));
  assign mem_req_o  = (st_q == S_REQ);
  assign mem_addr_o = waddr_q;
  assign tx_valid_o = (st_q == S_OUT);
  assign tx_data_o  = word_q[{lane_q, 3'b000} +: 8];
  assign tx_sop_o   = tx_valid_o && first_q && fs_q;
  assign tx_eop_o   = tx_valid_o && last_byte && ls_q;
  assign done_o     = tx_valid_o && tx_ready_i && last_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      waddr_q <= '0;
      lane_q  <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      first_q <= 1'b0;
      fs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          waddr_q <= {addr_i[AW-1:2], 2'b00};
          lane_q  <= addr_i[1:0];
          cnt_q   <= len_i;
          fs_q    <= fs_i;
          ls_q    <= ls_i;
          first_q <= 1'b1;
          st_q    <= S_REQ;
        end
        S_REQ:  st_q <= S_WAIT;
        S_WAIT: begin
          word_q <= mem_rdata_i;
          st_q   <= S_OUT;
        end
        S_OUT: if (tx_ready_i) begin
          first_q <= 1'b0;
          cnt_q   <= cnt_q - LW'(1);
          if (last_byte) begin
            st_q <= S_IDLE;
          end else if (lane_q == 2'd3) begin
            lane_q  <= 2'd0;
            waddr_q <= waddr_q + AW'(4);
            st_q    <= S_REQ;
          end else begin
            lane_q <= lane_q + 2'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_eop_o) && $stable(tx_sop_o));
  // R5
  eop_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_eop_o |=> !tx_valid_o);
  // R5
  sop_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_sop_o |=> !tx_sop_o);
endmodule

// File: rtl/tde_ctrl.sv
module tde_ctrl
  import tde_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 8,
  parameter int LW    = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          tx_en_i,
  input  logic          doorbell_i,
  input  logic          base_wr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          strm_start_o,
  output logic [AW-1:0] strm_addr_o,
  output logic [LW-1:0] strm_len_o,
  output logic          strm_fs_o,
  output logic          strm_ls_o,
  input  logic          strm_done_i,
  output logic          strm_busy_o,
  output logic          tx_ok_o
);
  localparam int PAD_W = AW - IDX_W - DESC_SHIFT;

  ctrl_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      status_q;
  logic             pend_q;
  logic [AW-1:0]    desc_addr;

  assign desc_addr = base_i + {{PAD_W{1'b0}}, idx_q, {DESC_SHIFT{1'b0}}};

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_wdata_o = status_q;
    mem_wdata_o[OWN_BIT] = 1'b0;
    unique case (st_q)
      C_ST_REQ: mem_req_o = 1'b1;
      C_BA_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_addr + AW'(BUF_OFS);
      end
      C_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign strm_len_o   = status_q[LW-1:0];
  assign strm_fs_o    = status_q[FS_BIT];
  assign strm_ls_o    = status_q[LS_BIT];
  assign strm_addr_o  = mem_rdata_i[AW-1:0];
  assign strm_start_o = (st_q == C_BA_WAIT) && (strm_len_o != '0);
  assign strm_busy_o  = (st_q == C_STREAM);
  assign tx_ok_o      = (st_q == C_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= C_IDLE;
      idx_q    <= '0;
      status_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (doorbell_i && st_q != C_IDLE) pend_q <= 1'b1;
      if (base_wr_i) idx_q <= '0;
      else if (st_q == C_OK) idx_q <= status_q[EOR_BIT] ? '0 : idx_q + IDX_W'(1);
      unique case (st_q)
        C_IDLE:    if (doorbell_i && tx_en_i) st_q <= C_ST_REQ;
        C_ST_REQ:  st_q <= C_ST_WAIT;
        C_ST_WAIT: begin
          status_q <= mem_rdata_i;
          if (mem_rdata_i[OWN_BIT]) begin
            st_q <= C_BA_REQ;
          end else begin
            // a doorbell seen during the scan buys one more look
            st_q   <= (pend_q || doorbell_i) ? C_ST_REQ : C_IDLE;
            pend_q <= 1'b0;
          end
        end
        C_BA_REQ:  st_q <= C_BA_WAIT;
        C_BA_WAIT: st_q <= (strm_len_o != '0) ? C_STREAM : C_WB;
        C_STREAM:  if (strm_done_i) st_q <= C_WB;
        C_WB:      st_q <= C_OK;
        C_OK: begin
          if (tx_en_i) begin
            st_q <= C_ST_REQ;
          end else begin
            st_q   <= C_IDLE;
            pend_q <= 1'b0;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  // R7
  ok_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok_o |=> !tx_ok_o);
  // R7
  ok_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok_o |-> $past(mem_we_o));
  // R2
  db_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_IDLE) && doorbell_i && !tx_en_i |=> (st_q == C_IDLE));
  // R11
  stop_on_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok_o && !tx_en_i |=> !mem_req_o);
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
  import tde_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  output logic          tx_ok_o
);
  logic [AW-1:0]    base;
  logic             tx_en, doorbell, base_wr;
  logic             c_req, c_we, s_req;
  logic [AW-1:0]    c_addr, s_addr, st_addr;
  logic [31:0]      c_wdata;
  logic             st_start, st_fs, st_ls, st_done, st_busy;
  logic [LEN_W-1:0] st_len;

  tde_regs #(.AW(AW), .DW(32)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .base_o(base), .tx_en_o(tx_en), .doorbell_o(doorbell), .base_wr_o(base_wr)
  );

  tde_ctrl #(.AW(AW), .IDX_W(IDX_W), .LW(LEN_W)) ctrl_i (
    .clk_i, .rst_ni,
    .base_i(base), .tx_en_i(tx_en), .doorbell_i(doorbell), .base_wr_i(base_wr),
    .mem_req_o(c_req), .mem_we_o(c_we), .mem_addr_o(c_addr), .mem_wdata_o(c_wdata),
    .mem_rdata_i,
    .strm_start_o(st_start), .strm_addr_o(st_addr), .strm_len_o(st_len),
    .strm_fs_o(st_fs), .strm_ls_o(st_ls), .strm_done_i(st_done),
    .strm_busy_o(st_busy), .tx_ok_o
  );

  tde_streamer #(.AW(AW), .LW(LEN_W)) strm_i (
    .clk_i, .rst_ni,
    .start_i(st_start), .addr_i(st_addr), .len_i(st_len), .fs_i(st_fs), .ls_i(st_ls),
    .mem_req_o(s_req), .mem_addr_o(s_addr), .mem_rdata_i,
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_sop_o, .tx_eop_o,
    .done_o(st_done)
  );

  // streamer owns the memory port only while a frame is in flight
  assign mem_req_o   = st_busy ? s_req  : c_req;
  assign mem_we_o    = st_busy ? 1'b0   : c_we;
  assign mem_addr_o  = st_busy ? s_addr : c_addr;
  assign mem_wdata_o = c_wdata;
endmodule

// File: tb/tx_desc_engine_tb_top.sv
`timescale 1ns/1ps
module tx_desc_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        tx_valid_o, tx_sop_o, tx_eop_o, tx_ok_o;
  logic        tx_ready_i = 1'b1;
  logic [7:0]  tx_data_o;

  always #4 clk_i = ~clk_i;

  tx_desc_engine dut_i (.*);

  logic [31:0] mem [0:1023];
  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o[11:2]];
  end

  int n_checks = 0, n_err = 0;
  bit finished = 0;
  int rdy_rand = 0;
  logic [7:0]  cap_d [0:4095];
  logic        cap_s [0:4095];
  logic        cap_e [0:4095];
  int          cap_n = 0;
  logic [7:0]  exp_d [0:4095];
  logic        exp_s [0:4095];
  logic        exp_e [0:4095];
  int          exp_n = 0;
  logic [31:0] rd_log [0:8191];
  int          rd_n = 0, wr_n = 0, ok_n = 0;

  always @(negedge clk_i) begin
    if (rdy_rand != 0) tx_ready_i = ($urandom_range(0, 1) == 1);
    else tx_ready_i = 1'b1;
    if (rst_ni) begin
      if (tx_valid_o && tx_ready_i && cap_n < 4096) begin
        cap_d[cap_n] = tx_data_o; cap_s[cap_n] = tx_sop_o; cap_e[cap_n] = tx_eop_o;
        cap_n++;
      end
      if (mem_req_o && !mem_we_o && rd_n < 8192) begin rd_log[rd_n] = mem_addr_o; rd_n++; end
      if (mem_req_o && mem_we_o) wr_n++;
      if (tx_ok_o) ok_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 30) begin
      @(negedge clk_i);
      if (mem_req_o || tx_valid_o) q = 0; else q++;
    end
  endtask

  function automatic logic [31:0] mk_status(bit own, bit eor, bit fs, bit ls, int len);
    return {own, eor, fs, ls, 15'd0, 13'(len)};
  endfunction

  task automatic put_desc(input int a, input logic [31:0] st, input logic [31:0] buf_a);
    mem[a/4] = st; mem[a/4+1] = 32'h0; mem[a/4+2] = buf_a; mem[a/4+3] = 32'h0;
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    logic [31:0] w = mem[a[11:2]];
    return w[{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic add_exp(input logic [31:0] a, input int len, input bit fs, input bit ls);
    for (int i = 0; i < len; i++) begin
      exp_d[exp_n] = byte_at(a + 32'(i));
      exp_s[exp_n] = fs && (i == 0);
      exp_e[exp_n] = ls && (i == len - 1);
      exp_n++;
    end
  endtask

  function automatic int rd_count(input logic [31:0] a);
    int c = 0;
    for (int i = 0; i < rd_n; i++) if (rd_log[i] == a) c++;
    return c;
  endfunction

  task automatic clear_cap();
    cap_n = 0; exp_n = 0;
  endtask

  task automatic cmp_stream(input string tag);
    int bad_d = -1, bad_f = -1;
    check(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (bad_d < 0 && cap_d[i] != exp_d[i]) bad_d = i;
      if (bad_f < 0 && (cap_s[i] != exp_s[i] || cap_e[i] != exp_e[i])) bad_f = i;
    end
    check(bad_d < 0, {tag, " data"}, (bad_d < 0) ? 0 : cap_d[bad_d], (bad_d < 0) ? 0 : exp_d[bad_d]);
    check(bad_f < 0, {tag, " markers"}, (bad_f < 0) ? 0 : {cap_s[bad_f], cap_e[bad_f]},
          (bad_f < 0) ? 0 : {exp_s[bad_f], exp_e[bad_f]});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int rd0, wr0, ok0, l1, l2, l3, l5, l6, l7a;
    logic [31:0] b1, b2, b3, b5, b6, st1, st2, st3, st5, st6;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!mem_req_o && !tx_valid_o && !tx_ok_o, "R1 idle in reset", {mem_req_o, tx_valid_o, tx_ok_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!mem_req_o && !tx_valid_o && !tx_ok_o, "R1 idle after reset", {mem_req_o, tx_valid_o, tx_ok_o}, 0);

    // basic frame at index 0
    reg_write(2'd0, 32'h100);
    reg_write(2'd1, 32'h4);
    put_desc(32'h100, mk_status(1, 0, 1, 1, 60), 32'h400);
    put_desc(32'h110, mk_status(0, 0, 1, 1, 60), 32'h500);
    clear_cap(); add_exp(32'h400, 60, 1, 1);
    rd0 = rd_n; wr0 = wr_n; ok0 = ok_n;
    reg_write(2'd2, 32'h40);
    wait_quiet();
    check(rd_n > rd0 && rd_log[rd0] == 32'h100, "R1 first fetch at base", rd_log[rd0], 32'h100);
    cmp_stream("R4 R5 basic frame");
    check(mem[32'h100/4] == 32'h3000_003C, "R7 write-back", mem[32'h100/4], 32'h3000_003C);
    check(ok_n - ok0 == 1, "R7 one done pulse", ok_n - ok0, 1);
    check(rd_count(32'h110) == 1, "R8 next desc fetched once", rd_count(32'h110), 1);
    check(wr_n - wr0 == 1, "R3 no write for unowned", wr_n - wr0, 1);

    // R2 ignored doorbells
    mem[32'h110/4] = mk_status(1, 0, 1, 1, 60);
    rd0 = rd_n;
    reg_write(2'd1, 32'h0);
    reg_write(2'd2, 32'h40);
    wait_quiet();
    check(rd_n == rd0, "R2 doorbell with enable clear", rd_n - rd0, 0);
    reg_write(2'd1, 32'h4);
    reg_write(2'd2, 32'hBF);
    wait_quiet();
    check(rd_n == rd0, "R2 poll write without bit 6", rd_n - rd0, 0);

    // random frames, markers, wrap, backpressure
    rdy_rand = 1;
    l1 = $urandom_range(60, 200); l2 = $urandom_range(60, 200); l3 = $urandom_range(60, 200);
    b1 = 32'h400 + 32'($urandom_range(0, 3));
    b2 = 32'h600 + 32'($urandom_range(0, 3));
    b3 = 32'h800 + 32'($urandom_range(0, 3));
    st1 = mk_status(1, 0, 1, 1, l1); st2 = mk_status(1, 0, 0, 0, l2); st3 = mk_status(1, 1, 1, 1, l3);
    put_desc(32'h110, st1, b1); put_desc(32'h120, st2, b2); put_desc(32'h130, st3, b3);
    clear_cap(); add_exp(b1, l1, 1, 1); add_exp(b2, l2, 0, 0); add_exp(b3, l3, 1, 1);
    rd0 = rd_count(32'h100); ok0 = ok_n;
    reg_write(2'd2, 32'h40);
    wait_quiet();
    cmp_stream("R4 R5 R6 random frames");
    check(ok_n - ok0 == 3, "R8 scan runs over owned descs", ok_n - ok0, 3);
    check(rd_count(32'h100) == rd0 + 1, "R8 wrap to base after end-of-ring", rd_count(32'h100), rd0 + 1);
    check(rd_count(32'h140) == 0, "R8 no fetch past end-of-ring", rd_count(32'h140), 0);
    check(mem[32'h130/4] == (st3 & 32'h7FFF_FFFF), "R7 flags kept", mem[32'h130/4], st3 & 32'h7FFF_FFFF);
    check(mem[32'h120/4] == (st2 & 32'h7FFF_FFFF), "R7 middle write-back", mem[32'h120/4], st2 & 32'h7FFF_FFFF);

    // R9 base with stray low bits, index reset
    l5 = 61; b5 = 32'hA03;
    st5 = mk_status(1, 0, 1, 1, l5);
    put_desc(32'h200, st5, b5);
    put_desc(32'h210, mk_status(0, 0, 1, 1, 60), 32'h0);
    put_desc(32'h220, mk_status(0, 0, 1, 1, 60), 32'h0);
    reg_write(2'd0, 32'h2A5);
    clear_cap(); add_exp(b5, l5, 1, 1);
    rd0 = rd_n;
    reg_write(2'd2, 32'h40);
    wait_quiet();
    check(rd_log[rd0] == 32'h200, "R9 aligned base and index 0", rd_log[rd0], 32'h200);
    cmp_stream("R9 frame at new base");
    check(rd_count(32'h210) == 1, "R10 baseline single read", rd_count(32'h210), 1);

    // R10 doorbell during scan
    l6 = 150; b6 = 32'hB00 + 32'($urandom_range(0, 3));
    st6 = mk_status(1, 0, 1, 1, l6);
    put_desc(32'h210, st6, b6);
    clear_cap(); add_exp(b6, l6, 1, 1);
    reg_write(2'd2, 32'h40);
    repeat (20) @(negedge clk_i);
    reg_write(2'd2, 32'h40);
    wait_quiet();
    cmp_stream("R10 frame");
    check(rd_count(32'h220) == 2, "R10 rescan after late doorbell", rd_count(32'h220), 2);

    // R11 disable mid-frame
    l7a = 100;
    put_desc(32'h220, mk_status(1, 0, 1, 1, l7a), 32'hC00);
    put_desc(32'h230, mk_status(1, 0, 1, 1, 60), 32'hD00);
    clear_cap(); add_exp(32'hC00, l7a, 1, 1);
    ok0 = ok_n;
    reg_write(2'd2, 32'h40);
    repeat (20) @(negedge clk_i);
    reg_write(2'd1, 32'h0);
    wait_quiet();
    cmp_stream("R11 current frame completes");
    check(ok_n - ok0 == 1, "R11 one done pulse", ok_n - ok0, 1);
    check(mem[32'h220/4][31] == 1'b0, "R11 current desc returned", mem[32'h220/4][31], 0);
    check(rd_count(32'h230) == 0, "R11 next desc not fetched", rd_count(32'h230), 0);
    check(mem[32'h230/4][31] == 1'b1, "R11 next desc still owned", mem[32'h230/4][31], 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule